// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines onto sixteen level inputs of a legacy interrupt controller. Each request line has an 8-bit route byte, written and read through a byte-wide configuration port. A route value below 16 names the controller line that the request drives. A value of 16 or more detaches the request line completely.

The router keeps one level bit for every pair of controller line and request line, 64 bits at the default sizes. Each controller output is the OR of the bits that belong to its line. When software writes a new route, the bit map is cleared and rebuilt from the present request levels under the new routing. This happens on the same clock edge that stores the byte, so no stale level survives a reroute.

Two combinational helpers sit beside the router. A route report gives, for a selected request line, whether it is connected and to which controller line. A slot swizzle turns a device's device/function number and INTx pin into the request line that the pin is wired to.

Top module: `pirq_router`

## Requirements
- R1: After reset, all four route bytes read 0x80, every controller output is 0, and the route report shows every request line as disconnected.
- R2: A configuration write to offset 0x60 + p (p = 0 for request A up to 3 for request D) stores the byte for request p. A read at that offset returns the stored byte unchanged. A read at any other offset returns 0x00, and a write to any other offset changes no route byte.
- R3: A request line whose route byte is 16 or more is disconnected. Its level has no effect on any output, and the route report gives connected = 0 and line code 0xFF (minus one).
- R4: One clock after a request level is sampled, controller output L is 1 exactly when at least one connected request line routed to L is high. The output is the OR over all request lines that share L.
- R5: A route write rebuilds the whole level map on the edge that stores it. From the next cycle on, the outputs follow the new routing with the current request levels, and the line the request left drops at once.
- R6: The swizzle returns (intx + slot - 1) mod 4, where slot is the device/function number shifted right by 3 and intx is 0..3 for pins A..D.
- R7: For a request line with a route byte from 0 to 15, the route report gives connected = 1 and the byte value as the line code. The value 15 is the highest that still connects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_in | input | 4 | Request line levels, sampled on every clock |
| cfg_wr_en | input | 1 | Configuration write strobe for one byte |
| cfg_addr | input | 8 | Configuration byte offset for both write and read |
| cfg_wr_data | input | 8 | Configuration write byte |
| cfg_rd_data | output | 8 | Configuration read byte at cfg_addr (combinational) |
| pic_out | output | 16 | Level outputs to the interrupt controller |
| rpt_pin | input | 2 | Request line selected for the route report |
| rpt_on | output | 1 | Selected request line is connected |
| rpt_line | output | 8 | Connected line number, or 0xFF when disconnected |
| swz_devfn | input | 8 | Device/function number for the swizzle |
| swz_intx | input | 2 | INTx pin for the swizzle, 0..3 = A..D |
| swz_pirq | output | 2 | Request line the pin maps to |

## Verification
A request level sampled on one rising edge shows on pic_out after that edge, so each output is due one cycle after its stimulus. A route write updates the stored byte and the rebuilt map on its own edge, so read-back and the new routing are both due in the following cycle. The bench's model updates on each rising edge from the same sampled inputs and is compared with pic_out on each falling edge. Read data, the route report and the swizzle are combinational, and they are checked a short delay after their inputs change, away from any clock edge.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
    localparam int BYTE_W      = 8;
    localparam logic [BYTE_W-1:0] ROUTE_RESET = 8'h80;
    localparam logic [BYTE_W-1:0] LINE_NONE   = 8'hFF;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int PIRQ_N     = 4,
    parameter int ADDR_W     = 8,
    parameter int ROUTE_BASE = 'h60
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [BYTE_W-1:0]              wr_data,
    output logic [BYTE_W-1:0]              rd_data,
    output logic [PIRQ_N-1:0][BYTE_W-1:0]  route_q,
    output logic [PIRQ_N-1:0][BYTE_W-1:0]  route_d,
    output logic                           wr_hit
);
    typedef struct packed {
        logic [PIRQ_N-1:0][BYTE_W-1:0] route;
    } regs_t;

    regs_t st_d, st_q;
    logic [PIRQ_N-1:0] sel;

    always_comb begin
        st_d    = st_q;
        rd_data = '0;
        for (int p = 0; p < PIRQ_N; p++) begin
            sel[p] = (addr == ADDR_W'(ROUTE_BASE + p));
            if (sel[p]) begin
                rd_data = st_q.route[p];
                if (wr_en) st_d.route[p] = wr_data;
            end
        end
        wr_hit = wr_en && (|sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < PIRQ_N; p++) st_q.route[p] <= ROUTE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_q = st_q.route;
    assign route_d = st_d.route;
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int PIRQ_N = 4,
    parameter int LINE_N = 16,
    localparam int MAP_W      = PIRQ_N * LINE_N,
    localparam int MAP_IDX_W  = $clog2(MAP_W),
    localparam int LINE_IDX_W = $clog2(LINE_N)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PIRQ_N-1:0]              pirq_in,
    input  logic [PIRQ_N-1:0][BYTE_W-1:0]  route_d,
    input  logic                           rebuild,
    output logic [MAP_W-1:0]               map_q
);
    typedef struct packed {
        logic [MAP_W-1:0] map;
    } map_t;

    map_t st_d, st_q;
    logic [MAP_IDX_W-1:0] idx;

    always_comb begin
        st_d = st_q;
        idx  = '0;
        if (rebuild) st_d.map = '0;
        for (int p = 0; p < PIRQ_N; p++) begin
            if (int'(route_d[p]) < LINE_N) begin
                idx = MAP_IDX_W'(route_d[p][LINE_IDX_W-1:0]) * MAP_IDX_W'(PIRQ_N)
                    + MAP_IDX_W'(p);
                st_d.map[idx] = pirq_in[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_q = st_q.map;
endmodule

// File: rtl/pirq_line_or.sv
module pirq_line_or #(
    parameter int PIRQ_N = 4,
    parameter int LINE_N = 16
) (
    input  logic [PIRQ_N*LINE_N-1:0] map,
    output logic [LINE_N-1:0]        line_out
);
    for (genvar l = 0; l < LINE_N; l++) begin : g_line
        assign line_out[l] = |map[l*PIRQ_N +: PIRQ_N];
    end
endmodule

// File: rtl/pirq_route_report.sv
module pirq_route_report
    import pirq_router_pkg::*;
#(
    parameter int PIRQ_N = 4,
    parameter int LINE_N = 16,
    localparam int PIN_W = $clog2(PIRQ_N)
) (
    input  logic [PIRQ_N-1:0][BYTE_W-1:0] route,
    input  logic [PIN_W-1:0]              pin,
    output logic                          on,
    output logic [BYTE_W-1:0]             line
);
    logic [BYTE_W-1:0] sel_route;

    always_comb begin
        sel_route = route[pin];
        on        = int'(sel_route) < LINE_N;
        line      = on ? sel_route : LINE_NONE;
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int PIRQ_N     = 4,
    parameter int LINE_N     = 16,
    parameter int ADDR_W     = 8,
    parameter int DEVFN_W    = 8,
    parameter int ROUTE_BASE = 'h60,
    localparam int PIN_W = $clog2(PIRQ_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIRQ_N-1:0]    pirq_in,
    input  logic                 cfg_wr_en,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [BYTE_W-1:0]    cfg_wr_data,
    output logic [BYTE_W-1:0]    cfg_rd_data,
    output logic [LINE_N-1:0]    pic_out,
    input  logic [PIN_W-1:0]     rpt_pin,
    output logic                 rpt_on,
    output logic [BYTE_W-1:0]    rpt_line,
    input  logic [DEVFN_W-1:0]   swz_devfn,
    input  logic [PIN_W-1:0]     swz_intx,
    output logic [PIN_W-1:0]     swz_pirq
);
    logic [PIRQ_N-1:0][BYTE_W-1:0] route_q;
    logic [PIRQ_N-1:0][BYTE_W-1:0] route_d;
    logic                          wr_hit;
    logic [PIRQ_N*LINE_N-1:0]      map_q;

    pirq_route_regs #(.PIRQ_N(PIRQ_N), .ADDR_W(ADDR_W), .ROUTE_BASE(ROUTE_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wr_data(cfg_wr_data), .rd_data(cfg_rd_data),
        .route_q(route_q), .route_d(route_d), .wr_hit(wr_hit)
    );

    pirq_level_map #(.PIRQ_N(PIRQ_N), .LINE_N(LINE_N)) u_map (
        .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .route_d(route_d),
        .rebuild(wr_hit), .map_q(map_q)
    );

    pirq_line_or #(.PIRQ_N(PIRQ_N), .LINE_N(LINE_N)) u_or (
        .map(map_q), .line_out(pic_out)
    );

    pirq_route_report #(.PIRQ_N(PIRQ_N), .LINE_N(LINE_N)) u_rpt (
        .route(route_q), .pin(rpt_pin), .on(rpt_on), .line(rpt_line)
    );

    always_comb begin
        swz_pirq = PIN_W'(swz_devfn >> 3) + swz_intx - PIN_W'(1);
    end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_router_pkg::*;
#(
    parameter int PIRQ_N     = 4,
    parameter int LINE_N     = 16,
    parameter int ADDR_W     = 8,
    parameter int DEVFN_W    = 8,
    parameter int ROUTE_BASE = 'h60,
    localparam int PIN_W      = $clog2(PIRQ_N),
    localparam int LINE_IDX_W = $clog2(LINE_N)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [PIRQ_N-1:0]             pirq_in,
    input logic                          cfg_wr_en,
    input logic [ADDR_W-1:0]             cfg_addr,
    input logic [BYTE_W-1:0]             cfg_wr_data,
    input logic [PIRQ_N-1:0][BYTE_W-1:0] route,
    input logic                          wr_hit,
    input logic [LINE_N-1:0]             pic_out,
    input logic                          rpt_on,
    input logic [BYTE_W-1:0]             rpt_line,
    input logic [DEVFN_W-1:0]            swz_devfn,
    input logic [PIN_W-1:0]              swz_intx,
    input logic [PIN_W-1:0]              swz_pirq
);
    logic all_off;
    always_comb begin
        all_off = 1'b1;
        for (int p = 0; p < PIRQ_N; p++)
            if (int'(route[p]) < LINE_N) all_off = 1'b0;
    end

    for (genvar p = 0; p < PIRQ_N; p++) begin : g_pirq
        assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_addr == ADDR_W'(ROUTE_BASE + p)) |=> route[p] == $past(cfg_wr_data));

        assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(pirq_in[p]) && !$past(wr_hit) && $past(int'(route[p]) < LINE_N))
            |-> pic_out[$past(route[p][LINE_IDX_W-1:0])]);
    end

    assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pic_out) <= PIRQ_N);

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(all_off) && !$past(wr_hit)) |-> pic_out == '0);

    assert_offcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_on |-> rpt_line == LINE_NONE);

    assert_swz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (swz_devfn[DEVFN_W-1:3] == 1) |-> swz_pirq == swz_intx);
endmodule

bind pirq_router pirq_router_chk #(
    .PIRQ_N(PIRQ_N), .LINE_N(LINE_N), .ADDR_W(ADDR_W),
    .DEVFN_W(DEVFN_W), .ROUTE_BASE(ROUTE_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data), .route(route_q),
    .wr_hit(wr_hit), .pic_out(pic_out), .rpt_on(rpt_on), .rpt_line(rpt_line),
    .swz_devfn(swz_devfn), .swz_intx(swz_intx), .swz_pirq(swz_pirq)
);

// File: tb/pirq_router_test.sv
`timescale 1ns/1ps
module pirq_router_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  pirq_in = '0;
    logic        cfg_wr_en = 0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic [15:0] pic_out;
    logic [1:0]  rpt_pin = '0;
    logic        rpt_on;
    logic [7:0]  rpt_line;
    logic [7:0]  swz_devfn = '0;
    logic [1:0]  swz_intx = '0;
    logic [1:0]  swz_pirq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    pirq_router uut (
        .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .cfg_wr_en(cfg_wr_en),
        .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .pic_out(pic_out), .rpt_pin(rpt_pin), .rpt_on(rpt_on), .rpt_line(rpt_line),
        .swz_devfn(swz_devfn), .swz_intx(swz_intx), .swz_pirq(swz_pirq)
    );

    always #5 clk = ~clk;

    // behavioural model: route values and one level flag per (line, request)
    int m_route[4];
    bit m_lvl[16][4];
    bit m_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) m_route[p] = 128;
            for (int l = 0; l < 16; l++)
                for (int p = 0; p < 4; p++) m_lvl[l][p] = 0;
        end else begin
            m_hit = 0;
            if (cfg_wr_en && cfg_addr >= 8'h60 && cfg_addr <= 8'h63) begin
                m_route[cfg_addr - 8'h60] = cfg_wr_data;
                m_hit = 1;
            end
            if (m_hit)
                for (int l = 0; l < 16; l++)
                    for (int p = 0; p < 4; p++) m_lvl[l][p] = 0;
            for (int p = 0; p < 4; p++)
                if (m_route[p] < 16) m_lvl[m_route[p]][p] = pirq_in[p];
        end
    end

    function automatic logic [15:0] model_pic();
        logic [15:0] v = '0;
        for (int l = 0; l < 16; l++)
            for (int p = 0; p < 4; p++) if (m_lvl[l][p]) v[l] = 1'b1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4 / R5: every cycle the outputs follow the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] e;
            e = model_pic();
            chk(pic_out === e, "R4 per-cycle output", 32'(pic_out), 32'(e));
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic cfg_read_chk(input logic [7:0] a, input logic [7:0] e, input string req);
        cfg_addr = a;
        #1;
        chk(cfg_rd_data === e, req, 32'(cfg_rd_data), 32'(e));
    endtask

    task automatic rpt_chk(input logic [1:0] pin, input bit e_on, input logic [7:0] e_line,
                           input string req);
        rpt_pin = pin;
        #1;
        chk(rpt_on === e_on && rpt_line === e_line, req,
            32'({rpt_on, rpt_line}), 32'({e_on, e_line}));
    endtask

    task automatic swz_chk(input logic [7:0] devfn, input logic [1:0] intx, input logic [1:0] e);
        swz_devfn = devfn; swz_intx = intx;
        #1;
        chk(swz_pirq === e, "R6 swizzle", 32'(swz_pirq), 32'(e));
    endtask

    task automatic wait_pic(input logic [3:0] lv, input logic [15:0] e, input string req);
        @(negedge clk);
        pirq_in = lv;
        @(negedge clk);
        #1;
        chk(pic_out === e, req, 32'(pic_out), 32'(e));
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(pic_out === 16'h0, "R1 reset outputs", 32'(pic_out), 0);
        for (int p = 0; p < 4; p++) cfg_read_chk(8'(8'h60 + p), 8'h80, "R1 reset route byte");
        rpt_chk(2'd0, 0, 8'hFF, "R1 reset report");

        cfg_write(8'h60, 8'd5);
        cfg_write(8'h61, 8'd5);
        cfg_write(8'h62, 8'd9);
        cfg_write(8'h63, 8'd15);
        cfg_read_chk(8'h60, 8'd5, "R2 read back A");
        cfg_read_chk(8'h62, 8'd9, "R2 read back C");
        cfg_read_chk(8'h63, 8'd15, "R2 read back D");
        rpt_chk(2'd3, 1, 8'd15, "R7 report line 15");
        rpt_chk(2'd2, 1, 8'd9, "R7 report line 9");

        wait_pic(4'b0001, 16'h0020, "R4 A on line 5");
        wait_pic(4'b0011, 16'h0020, "R4 A|B share line 5");
        wait_pic(4'b0010, 16'h0020, "R4 B alone on line 5");
        wait_pic(4'b1000, 16'h8000, "R4 D on line 15");
        wait_pic(4'b0100, 16'h0200, "R4 C on line 9");
        wait_pic(4'b0000, 16'h0000, "R4 all low");

        cfg_write(8'h60, 8'h10);
        wait_pic(4'b0001, 16'h0000, "R3 A detached ignored");
        rpt_chk(2'd0, 0, 8'hFF, "R3 report detached");
        cfg_read_chk(8'h60, 8'h10, "R2 detached byte kept");

        wait_pic(4'b0010, 16'h0020, "R4 B on line 5");
        cfg_write(8'h61, 8'd12);
        #1;
        chk(pic_out === 16'h1000, "R5 reroute B to 12", 32'(pic_out), 32'h1000);

        cfg_write(8'h64, 8'h03);
        cfg_write(8'h5F, 8'h03);
        cfg_read_chk(8'h64, 8'h00, "R2 read outside range");
        cfg_read_chk(8'h5F, 8'h00, "R2 read below range");
        cfg_read_chk(8'h61, 8'd12, "R2 B unchanged");
        cfg_read_chk(8'h63, 8'd15, "R2 D unchanged");

        swz_chk(8'h08, 2'd2, 2'd2);
        swz_chk(8'h00, 2'd0, 2'd3);
        swz_chk(8'h18, 2'd3, 2'd1);
        swz_chk(8'hF8, 2'd1, 2'd3);
        swz_chk(8'h10, 2'd0, 2'd1);

        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pirq_in = lfsr[3:0];
            if (lfsr[6:4] == 3'd0) begin
                cfg_wr_en = 1;
                cfg_addr = 8'(8'h5E + (lfsr[9:7] % 8));
                cfg_wr_data = {3'b000, lfsr[15:11]};
            end else begin
                cfg_wr_en = 0;
            end
        end
        @(negedge clk);
        cfg_wr_en = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule